// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours, day of month, month, a two-digit year standing for 2000 to 2099, and a weekday counter. A divider counts enable pulses from a 32.768 kHz reference. Each time a full second of pulses has passed, the calendar advances by one second and ripples carries through every field, with real month lengths and leap years. Hours run either 00 to 23 or 01 to 12 with a PM flag.

Software reaches everything through a byte-wide register port. To set the clock it clears the run bit, writes the fields and sets run again. A snapshot command freezes a copy of the live time in a capture bank, so a multi-byte read cannot tear. A round command snaps the time to the nearest whole minute at the next second. Sticky status flags record second, minute, hour and day boundaries and an alarm match. A level interrupt follows whichever of those flags are enabled.

Register offsets: 0x00 to 0x06 live time (seconds, minutes, hours, day, month, year, weekday); 0x08 to 0x0E capture bank in the same order; 0x10 to 0x15 alarm (seconds to year); 0x18 control; 0x19 status; 0x1A interrupt setup.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0; control reads 0x00 (frozen); status reads 0x80 (power-up flag); the interrupt is low.
- R2: A write to a live time register (0x00 to 0x06) is taken only while control bit 0 (run) is 0; while running it is ignored. Written values are masked to the field width (hours keep bit 7 as PM and bits 5:0).
- R3: While running, the seconds advance once per TICKS_PER_SEC reference pulses. While frozen nothing advances, and the divider restarts from zero when run is set again.
- R4: Seconds and minutes wrap 59 to 00 and carry on; in 24-hour mode (control bit 3 = 0) hours wrap 23 to 00 and carry into the day.
- R5: In 12-hour mode (control bit 3 = 1) hours count 01 to 12; 11 to 12 toggles the PM bit (hours bit 7); 12 goes to 01; 11 PM to 12 AM carries into the day.
- R6: The day wraps after the last day of the month (30 for months 04, 06, 09, 11; February 29 when the year value is divisible by 4, else 28; otherwise 31); month 12 wraps to 01 and increments the year; year 99 wraps to 00; the weekday counts 0 to 6 and wraps on each day carry.
- R7: Writing control with bit 6 set copies the live time into the capture bank (0x08 to 0x0E), which then holds while the clock keeps running; bit 6 reads back as 0.
- R8: Control bit 1 requests rounding: at the next second boundary seconds become 00 and the minute advances if seconds were 0x30 or more; the bit then reads 0.
- R9: Status bits 2, 3, 4, 5 set at each second, minute, hour and day boundary; status bit 1 reads the run bit.
- R10: Status bit 6 sets when, at a second boundary, the new seconds, minutes, hours (with PM), day, month and year all equal the alarm registers.
- R11: Writing 1 to a status bit (2 to 7) clears it; a flag that sets in the same cycle as its clear stays set.
- R12: The interrupt rises one cycle after an enabled flag is pending: interrupt register bit 2 enables the periodic flag picked by bits 1:0 (0 second, 1 minute, 2 hour, 3 day), bit 3 enables the alarm flag; with none pending it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ref | input | 1 | One-cycle enable per 32.768 kHz reference period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for bus_addr, one cycle later |
| irq | output | 1 | Level interrupt |

## Verification
The status clear and the flag set can land on the same clock edge: the bench holds the reference enable so that a second boundary falls exactly on the edge that carries a write-one-to-clear of the second flag, and then expects the flag still set; a clear off the boundary must empty it. Snapshot and counting also overlap in use, so the capture bank is read after further seconds have passed and must still match the earlier time. Rollovers through every field, both hour modes and leap years are driven by randomised near-boundary start times checked against a binary calendar model in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BYTE_W  = 8;
  localparam int NFIELD  = 7;
  localparam int NALARM  = 6;

  // register offsets
  localparam int OFS_TIME  = 0;
  localparam int OFS_CAP   = 8;
  localparam int OFS_ALM   = 16;
  localparam int OFS_CTRL  = 24;
  localparam int OFS_STAT  = 25;
  localparam int OFS_INTR  = 26;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] day;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] year;
    logic [2:0]        wday;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year value (00..99 BCD) divisible by four: (2*tens + ones) mod 4 == 0
  function automatic logic leap_year(input logic [7:0] y);
    logic [1:0] s;
    s = {y[4], 1'b0} + y[1:0];
    return s == 2'd0;
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_of(input rtc_time_t t, input logic [2:0] idx);
    case (idx)
      3'd0:    return t.sec;
      3'd1:    return t.min;
      3'd2:    return t.hour;
      3'd3:    return t.day;
      3'd4:    return t.mon;
      3'd5:    return t.year;
      3'd6:    return {5'd0, t.wday};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic sec_stb
);
  localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign sec_stb = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt_q <= '0;
    else if (sec_stb)  cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
  p_period_r3: assert property (@(posedge clk) disable iff (rst)
    sec_stb |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sec_stb,
  input  logic        mode12,
  input  logic        round_req,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  output rtc_time_t   t_q,
  output rtc_time_t   t_nxt,
  output logic [3:0]  ev
);
  logic c_min, c_hr, c_day;
  logic [5:0] hr;
  logic       pm;

  always_comb begin
    t_nxt = t_q;
    ev    = 4'b0001;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    hr    = t_q.hour[5:0];
    pm    = t_q.hour[7];
    // seconds, with optional round to nearest minute
    if (round_req) begin
      t_nxt.sec = 8'h00;
      c_min     = (t_q.sec >= 8'h30);
    end else if (t_q.sec >= 8'h59) begin
      t_nxt.sec = 8'h00;
      c_min     = 1'b1;
    end else begin
      t_nxt.sec = bcd_inc(t_q.sec);
    end
    // minutes
    if (c_min) begin
      ev[1] = 1'b1;
      if (t_q.min >= 8'h59) begin
        t_nxt.min = 8'h00;
        c_hr      = 1'b1;
      end else begin
        t_nxt.min = bcd_inc(t_q.min);
      end
    end
    // hours
    if (c_hr) begin
      ev[2] = 1'b1;
      if (mode12) begin
        if (hr == 6'h11) begin
          t_nxt.hour = {~pm, 7'h12};
          c_day      = pm;
        end else if (hr == 6'h12) begin
          t_nxt.hour = {pm, 7'h01};
        end else begin
          t_nxt.hour = {pm, 7'h00} | (bcd_inc({2'b00, hr}) & 8'h3F);
        end
      end else if (hr >= 6'h23) begin
        t_nxt.hour = 8'h00;
        c_day      = 1'b1;
      end else begin
        t_nxt.hour = {pm, 7'h00} | (bcd_inc({2'b00, hr}) & 8'h3F);
      end
    end
    // date
    if (c_day) begin
      ev[3]      = 1'b1;
      t_nxt.wday = (t_q.wday >= 3'd6) ? 3'd0 : t_q.wday + 3'd1;
      if (t_q.day >= last_day(t_q.mon, t_q.year)) begin
        t_nxt.day = 8'h01;
        if (t_q.mon >= 8'h12) begin
          t_nxt.mon  = 8'h01;
          t_nxt.year = (t_q.year >= 8'h99) ? 8'h00 : bcd_inc(t_q.year);
        end else begin
          t_nxt.mon = bcd_inc(t_q.mon);
        end
      end else begin
        t_nxt.day = bcd_inc(t_q.day);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
               mon: 8'h01, year: 8'h00, wday: 3'd0};
    end else if (wr_en) begin
      case (wr_sel)
        3'd0:    t_q.sec  <= wr_data & 8'h7F;
        3'd1:    t_q.min  <= wr_data & 8'h7F;
        3'd2:    t_q.hour <= wr_data & 8'hBF;
        3'd3:    t_q.day  <= wr_data & 8'h3F;
        3'd4:    t_q.mon  <= wr_data & 8'h1F;
        3'd5:    t_q.year <= wr_data;
        default: t_q.wday <= wr_data[2:0];
      endcase
    end else if (sec_stb) begin
      t_q <= t_nxt;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!sec_stb && !wr_en) |=> $stable(t_q));
  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (sec_stb && !wr_en && !round_req && t_q.sec == 8'h59) |=>
      (t_q.sec == 8'h00 && t_q.min != $past(t_q.min)));

endmodule

// File: rtl/rtc_status.sv
module rtc_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_stb,
  input  logic [3:0] ev,
  input  logic       alm_hit,
  input  logic       clr_we,
  input  logic [7:2] clr_mask,
  input  logic       per_en,
  input  logic [1:0] per_sel,
  input  logic       alm_en,
  output logic [7:2] flags,
  output logic       irq
);
  logic [6:2] set_v;
  logic [6:2] flg_q;
  logic       pu_q;

  assign set_v = sec_stb ? {alm_hit, ev} : 5'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
      pu_q  <= 1'b1;
      irq   <= 1'b0;
    end else begin
      flg_q <= (flg_q & ~(clr_we ? clr_mask[6:2] : 5'b0)) | set_v;
      if (clr_we && clr_mask[7]) pu_q <= 1'b0;
      irq <= (per_en && flg_q[2 + per_sel]) || (alm_en && flg_q[6]);
    end
  end

  assign flags = {pu_q, flg_q};

  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (sec_stb && ev[0]) |=> flg_q[2]);
  p_w1c_r11: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_mask[3] && !sec_stb) |=> !flg_q[3]);
  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!per_en && !alm_en) |=> !irq);

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ref,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_INTR = ADDR_W'(OFS_INTR);

  logic       run_q, round_q, m12_q;
  logic       pen_q, aen_q;
  logic [1:0] psel_q;
  logic [7:0] alm_q [NALARM];
  rtc_time_t  cap_q;

  logic       sec_stb, wr_time, clr_we, alm_hit;
  logic [3:0] ev;
  logic [7:2] flags;
  rtc_time_t  t_q, t_nxt;

  assign wr_time = bus_we && !run_q && (bus_addr < ADDR_W'(OFS_TIME + NFIELD));
  assign clr_we  = bus_we && (bus_addr == A_STAT);
  assign alm_hit = (t_nxt.sec == alm_q[0]) && (t_nxt.min == alm_q[1]) &&
                   (t_nxt.hour == alm_q[2]) && (t_nxt.day == alm_q[3]) &&
                   (t_nxt.mon == alm_q[4]) && (t_nxt.year == alm_q[5]);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst(rst), .tick(tick_ref), .run(run_q), .sec_stb(sec_stb)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .sec_stb(sec_stb), .mode12(m12_q),
    .round_req(round_q), .wr_en(wr_time), .wr_sel(bus_addr[2:0]),
    .wr_data(bus_wdata), .t_q(t_q), .t_nxt(t_nxt), .ev(ev)
  );

  rtc_status u_stat (
    .clk(clk), .rst(rst), .sec_stb(sec_stb), .ev(ev), .alm_hit(alm_hit),
    .clr_we(clr_we), .clr_mask(bus_wdata[7:2]), .per_en(pen_q),
    .per_sel(psel_q), .alm_en(aen_q), .flags(flags), .irq(irq)
  );

  // control, interrupt setup, snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      round_q <= 1'b0;
      m12_q   <= 1'b0;
      pen_q   <= 1'b0;
      aen_q   <= 1'b0;
      psel_q  <= 2'd0;
      cap_q   <= '0;
    end else begin
      if (sec_stb) round_q <= 1'b0;
      if (bus_we && bus_addr == A_CTRL) begin
        run_q   <= bus_wdata[0];
        round_q <= bus_wdata[1];
        m12_q   <= bus_wdata[3];
        if (bus_wdata[6]) cap_q <= t_q;
      end
      if (bus_we && bus_addr == A_INTR) begin
        psel_q <= bus_wdata[1:0];
        pen_q  <= bus_wdata[2];
        aen_q  <= bus_wdata[3];
      end
    end
  end

  // alarm bank
  for (genvar g = 0; g < NALARM; g++) begin : g_alm
    always_ff @(posedge clk) begin
      if (rst) alm_q[g] <= 8'h00;
      else if (bus_we && bus_addr == ADDR_W'(OFS_ALM + g)) alm_q[g] <= bus_wdata;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else if (bus_addr < ADDR_W'(OFS_TIME + NFIELD)) begin
      bus_rdata <= field_of(t_q, bus_addr[2:0]);
    end else if (bus_addr >= ADDR_W'(OFS_CAP) && bus_addr < ADDR_W'(OFS_CAP + NFIELD)) begin
      bus_rdata <= field_of(cap_q, bus_addr[2:0]);
    end else if (bus_addr >= ADDR_W'(OFS_ALM) && bus_addr < ADDR_W'(OFS_ALM + NALARM)) begin
      bus_rdata <= alm_q[bus_addr[2:0]];
    end else if (bus_addr == A_CTRL) begin
      bus_rdata <= {4'b0000, m12_q, 1'b0, round_q, run_q};
    end else if (bus_addr == A_STAT) begin
      bus_rdata <= {flags, run_q, 1'b0};
    end else if (bus_addr == A_INTR) begin
      bus_rdata <= {4'b0000, aen_q, pen_q, psel_q};
    end else begin
      bus_rdata <= 8'h00;
    end
  end

  p_frozen_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && run_q && bus_addr == ADDR_W'(OFS_TIME) && !sec_stb) |=> $stable(t_q.sec));
  p_round_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (sec_stb && !(bus_we && bus_addr == A_CTRL)) |=> !round_q);

endmodule

// File: tb/bcd_rtc_tb_top.sv
module bcd_rtc_tb_top;
  localparam int TPS = 4;

  typedef struct {
    int s; int m; int h; int pm; int d; int mo; int y; int wd;
  } tm_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ref = 1'b0;
  logic       bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(TPS), .ADDR_W(5)) dut_i (
    .clk(clk), .rst(rst), .tick_ref(tick_ref), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_byte(input tm_t t);
    return 8'(t.pm << 7) | bcd(t.h);
  endfunction

  function automatic logic [63:0] pack(input tm_t t);
    return {8'h00, bcd(t.s), bcd(t.m), hour_byte(t), bcd(t.d), bcd(t.mo), bcd(t.y), 8'(t.wd)};
  endfunction

  function automatic tm_t next_day(input tm_t t);
    tm_t r = t;
    r.wd = (r.wd + 1) % 7;
    r.d++;
    if (r.d > dim(t.mo, t.y)) begin
      r.d = 1; r.mo++;
      if (r.mo > 12) begin r.mo = 1; r.y = (r.y + 1) % 100; end
    end
    return r;
  endfunction

  function automatic tm_t next_hour(input tm_t t, input bit m12);
    tm_t r = t;
    if (m12) begin
      if (r.h == 11) begin r.h = 12; r.pm = 1 - r.pm; if (r.pm == 0) r = next_day(r); end
      else if (r.h == 12) r.h = 1;
      else r.h++;
    end else begin
      r.h++;
      if (r.h == 24) begin r.h = 0; r = next_day(r); end
    end
    return r;
  endfunction

  function automatic tm_t next_min(input tm_t t, input bit m12);
    tm_t r = t;
    r.m++;
    if (r.m == 60) begin r.m = 0; r = next_hour(r, m12); end
    return r;
  endfunction

  function automatic tm_t next_sec(input tm_t t, input bit m12);
    tm_t r = t;
    r.s++;
    if (r.s == 60) begin r.s = 0; r = next_min(r, m12); end
    return r;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic read_bank(input logic [4:0] base, output logic [63:0] v);
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < 7; i++) begin
      rd(base + 5'(i), b);
      v = {v[55:0], b};
    end
  endtask

  task automatic set_time(input tm_t t, input bit m12);
    wr(5'h18, {4'b0, m12, 3'b000});
    wr(5'h00, bcd(t.s)); wr(5'h01, bcd(t.m)); wr(5'h02, hour_byte(t));
    wr(5'h03, bcd(t.d)); wr(5'h04, bcd(t.mo)); wr(5'h05, bcd(t.y));
    wr(5'h06, 8'(t.wd));
    wr(5'h18, {4'b0, m12, 3'b001});
  endtask

  task automatic ticks(input int k);
    @(negedge clk);
    tick_ref = 1'b1;
    repeat (k) @(negedge clk);
    tick_ref = 1'b0;
  endtask

  task automatic adv(input int n);
    ticks(TPS * n);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [63:0] v, v0;
    logic [7:0]  b;
    tm_t t, e;
    void'($urandom(32'd20240229));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    read_bank(5'h00, v);
    check("R1 time", v, {8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00});
    rd(5'h18, b); check("R1 ctrl", 64'(b), 64'h00);
    rd(5'h19, b); check("R1 status", 64'(b), 64'h80);
    check("R1 irq", 64'(irq), 64'h0);

    // R11 power-up flag clears on write of one
    wr(5'h19, 8'h80);
    rd(5'h19, b); check("R11 power-up clear", 64'(b), 64'h00);

    // R2 write while running ignored
    t = '{s: 10, m: 20, h: 8, pm: 0, d: 3, mo: 5, y: 21, wd: 2};
    set_time(t, 1'b0);
    wr(5'h00, 8'h33);
    rd(5'h00, b); check("R2 running write ignored", 64'(b), 64'(bcd(10)));
    read_bank(5'h00, v); check("R2 frozen write taken", v, pack(t));

    // R3 frozen: no advance
    wr(5'h18, 8'h00);
    ticks(3 * TPS);
    rd(5'h00, b); check("R3 frozen holds", 64'(b), 64'(bcd(10)));
    // R3 divider restart on run
    wr(5'h18, 8'h01);
    ticks(TPS - 1);
    wr(5'h18, 8'h00);
    wr(5'h18, 8'h01);
    ticks(TPS - 1);
    rd(5'h00, b); check("R3 divider restarted", 64'(b), 64'(bcd(10)));
    ticks(1);
    rd(5'h00, b); check("R3 one second", 64'(b), 64'(bcd(11)));

    // R9 events across a full day rollover, R6 month end
    t = '{s: 59, m: 59, h: 23, pm: 0, d: 30, mo: 4, y: 23, wd: 6};
    set_time(t, 1'b0);
    wr(5'h19, 8'hFC);
    adv(1);
    read_bank(5'h00, v); check("R6 April end", v, pack(next_sec(t, 1'b0)));
    rd(5'h19, b); check("R9 all events", 64'(b), 64'h3E);

    // R6 leap year and non-leap February, year wrap
    t = '{s: 59, m: 59, h: 23, pm: 0, d: 28, mo: 2, y: 24, wd: 3};
    set_time(t, 1'b0); adv(1);
    read_bank(5'h00, v); check("R6 leap Feb 29", v, {8'h00, 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h04});
    t.y = 23;
    set_time(t, 1'b0); adv(1);
    read_bank(5'h00, v); check("R6 non-leap Mar 1", v, {8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, 8'h04});
    t = '{s: 59, m: 59, h: 23, pm: 0, d: 31, mo: 12, y: 99, wd: 5};
    set_time(t, 1'b0); adv(1);
    read_bank(5'h00, v); check("R6 year wrap", v, {8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h06});

    // R5 twelve-hour mode
    t = '{s: 59, m: 59, h: 11, pm: 0, d: 10, mo: 7, y: 30, wd: 1};
    set_time(t, 1'b1); adv(1);
    rd(5'h02, b); check("R5 11AM to 12PM", 64'(b), 64'h92);
    wr(5'h18, 8'h08); wr(5'h00, 8'h59); wr(5'h01, 8'h59); wr(5'h18, 8'h09);
    adv(1);
    rd(5'h02, b); check("R5 12PM to 1PM", 64'(b), 64'h81);
    t = '{s: 59, m: 59, h: 11, pm: 1, d: 10, mo: 7, y: 30, wd: 1};
    set_time(t, 1'b1); adv(1);
    read_bank(5'h00, v); check("R5 11PM to 12AM", v, {8'h00, 8'h00, 8'h00, 8'h12, 8'h11, 8'h07, 8'h30, 8'h02});

    // R4 24-hour minute and hour carry
    t = '{s: 59, m: 59, h: 9, pm: 0, d: 1, mo: 1, y: 5, wd: 0};
    set_time(t, 1'b0); adv(1);
    read_bank(5'h00, v); check("R4 hour carry", v, pack(next_sec(t, 1'b0)));

    // R7 snapshot
    t = '{s: 5, m: 6, h: 7, pm: 0, d: 8, mo: 9, y: 10, wd: 4};
    set_time(t, 1'b0);
    wr(5'h18, 8'h41);
    adv(2);
    read_bank(5'h08, v); check("R7 capture holds", v, pack(t));
    read_bank(5'h00, v); check("R7 live moved on", v, pack(next_sec(next_sec(t, 1'b0), 1'b0)));
    rd(5'h18, b); check("R7 snap bit reads zero", 64'(b), 64'h01);

    // R8 rounding up and down
    t = '{s: 44, m: 10, h: 5, pm: 0, d: 2, mo: 3, y: 40, wd: 1};
    set_time(t, 1'b0);
    wr(5'h18, 8'h03); adv(1);
    rd(5'h00, b); v0 = 64'(b); rd(5'h01, b);
    check("R8 round up", {v0[7:0], b}, 64'h0011);
    rd(5'h18, b); check("R8 request cleared", 64'(b), 64'h01);
    t.s = 12;
    set_time(t, 1'b0);
    wr(5'h18, 8'h03); adv(1);
    rd(5'h00, b); v0 = 64'(b); rd(5'h01, b);
    check("R8 round down", {v0[7:0], b}, 64'h0010);

    // R11 plain clear and set-wins collision
    wr(5'h19, 8'hFC);
    rd(5'h19, b); check("R11 clear", 64'(b), 64'h02);
    @(negedge clk);
    tick_ref = 1'b1;
    repeat (TPS - 1) @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h19; bus_wdata = 8'h04;
    @(negedge clk);
    tick_ref = 1'b0; bus_we = 1'b0;
    rd(5'h19, b); check("R11 set wins over clear", 64'(b[2]), 64'h1);

    // R12 periodic interrupt, minute selected
    wr(5'h1A, 8'h05);
    t = '{s: 58, m: 0, h: 0, pm: 0, d: 1, mo: 1, y: 1, wd: 0};
    set_time(t, 1'b0);
    wr(5'h19, 8'hFC);
    adv(1); @(negedge clk);
    check("R12 unselected flag quiet", 64'(irq), 64'h0);
    adv(1); @(negedge clk);
    check("R12 minute interrupt", 64'(irq), 64'h1);
    wr(5'h19, 8'h08); @(negedge clk);
    check("R12 interrupt drops", 64'(irq), 64'h0);

    // R10 alarm
    wr(5'h1A, 8'h08);
    t = '{s: 30, m: 20, h: 10, pm: 0, d: 15, mo: 6, y: 24, wd: 2};
    set_time(t, 1'b0);
    wr(5'h10, 8'h32); wr(5'h11, 8'h20); wr(5'h12, 8'h10);
    wr(5'h13, 8'h15); wr(5'h14, 8'h06); wr(5'h15, 8'h24);
    wr(5'h19, 8'hFC);
    adv(1);
    rd(5'h19, b); check("R10 no early alarm", 64'(b[6]), 64'h0);
    check("R12 alarm not pending", 64'(irq), 64'h0);
    adv(1);
    rd(5'h19, b); check("R10 alarm flag", 64'(b[6]), 64'h1);
    check("R12 alarm interrupt", 64'(irq), 64'h1);
    wr(5'h13, 8'h00);
    wr(5'h1A, 8'h00);

    // R4 R5 R6 randomised near-boundary starts
    for (int it = 0; it < 40; it++) begin
      bit m12;
      int n;
      m12  = 1'($urandom % 2);
      t.s  = ($urandom % 2) ? 59 : int'($urandom % 60);
      t.m  = ($urandom % 2) ? 59 : int'($urandom % 60);
      t.pm = 0;
      if (m12) begin
        t.h  = ($urandom % 2) ? 11 : int'($urandom % 12) + 1;
        t.pm = int'($urandom % 2);
      end else begin
        t.h = ($urandom % 2) ? 23 : int'($urandom % 24);
      end
      t.mo = ($urandom % 3 == 0) ? 12 : int'($urandom % 12) + 1;
      t.y  = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
      t.d  = ($urandom % 2) ? dim(t.mo, t.y) : int'($urandom % 28) + 1;
      t.wd = int'($urandom % 7);
      n    = int'($urandom % 3) + 1;
      set_time(t, m12);
      adv(n);
      e = t;
      for (int k = 0; k < n; k++) e = next_sec(e, m12);
      read_bank(5'h00, v);
      check("R4 R5 R6 random rollover", v, pack(e));
    end

    summary();
  end
endmodule